// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Controller

This block sits between a simple valid/ready host port and an asynchronous dynamic memory that has separate row and column strobes, a write enable, a shared 11-bit address bus, a data input pin and a data output pin. A host offers one access at a time: a 22-bit word address, a direction bit and, for writes, the data. The controller splits the address into a row half and a column half. It then runs one complete memory cycle, with every minimum pulse width and delay counted in clock cycles. When the cycle ends it raises a one-cycle done pulse, and for reads the sampled data comes with it.

After reset the memory needs time before it is usable. The controller first waits a fixed pause, which is derived from the clock rate and set to 200 microseconds by default. It then issues eight row-strobe-only cycles to bring up the memory's internal nodes. The memory also needs these eight strobes again if it sits unused for too long. A timer counts consecutive idle cycles, and when the programmed idle threshold is reached the controller issues the eight-strobe wake-up by itself. Writes always use the early-write form: write enable is already low when the column strobe falls, so the memory never drives its output during a write.

Top module: `dramc_top`

## Requirements
- R1: After reset is released, the row strobe does not fall for at least PAUSE_CYC = CLK_MHZ*PWRUP_US clock cycles, and the host ready signal stays low during that time.
- R2: After the pause, exactly INIT_STROBES (default 8) row-strobe pulses are issued with the column strobe held high. Ready first rises only after these pulses.
- R3: In an access, the address pins carry addr[21:11] when the row strobe falls and addr[10:0] when the column strobe falls. The address stays stable while the column strobe is low, and the column strobe is low only while the row strobe is low.
- R4: The column strobe falls exactly T_RCD clock cycles after the row strobe falls.
- R5: The column strobe stays low for exactly T_CAS cycles. The row strobe stays low for at least T_RAS cycles and rises only while the column strobe is high. It stays high for at least T_RP cycles before it falls again, and this holds for init and wake-up strobes too.
- R6: In a read, write enable is high for the whole cycle. resp_rdata equals the memory output sampled while the column strobe is still low. resp_done is a single-cycle pulse T_RCD+T_CAS+1 cycles after the accepting clock edge.
- R7: In a write, write enable is low from the row strobe fall until the column strobe rises (setup of T_RCD cycles), and it does not change while the column strobe is low. dram_d carries the request data while the column strobe is low. resp_done has the same timing as in a read.
- R8: req_ready is high only when no strobe is low and no init or wake-up sequence is running. During reset, both strobes and write enable are high, and ready and done are low.
- R9: After IDLE_LIMIT consecutive idle cycles, ready drops in that cycle and INIT_STROBES row-strobe-only pulses are issued before the next access. IDLE_LIMIT is CLK_MHZ times the standard or low-power idle time. Shorter idle gaps cause no wake-up pulses, and the idle count restarts after every access and every wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller can accept an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; upper half is the row, lower half the column |
| req_wdata | input | DATA_W | Write data |
| resp_done | output | 1 | One-cycle pulse at the end of each access |
| resp_rdata | output | DATA_W | Read data, valid with resp_done of a read |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W/2 | Multiplexed address pins |
| dram_d | output | DATA_W | Data to the memory |
| dram_q | input | DATA_W | Data from the memory |

## Verification
The hardest case to reach from the ports is a host request that arrives in the very cycle the idle timer expires. In that cycle ready must already be low, and the wake-up strobes must come before the access. The bench waits after an access, counts the ready-high cycles with no request offered, and checks that this count is exactly one less than the threshold. It then offers a request at once and checks that eight row-only strobes come before that request's column strobe. Randomized accesses with short gaps check that ordinary idle periods never trigger a wake-up.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_WRAS,
    ST_WPRE,
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_HOLD,
    ST_PRE
  } dram_st_t;

  typedef enum logic [1:0] {
    AM_ZERO,
    AM_ROW,
    AM_COL
  } amux_t;

  function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramc_idle_mon.sv
module dramc_idle_mon #(
  parameter int unsigned LIMIT = 1600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  output logic expire
);
  localparam int unsigned IW = $clog2(LIMIT + 1);

  logic [IW-1:0] cnt_q, cnt_nxt;

  assign expire = in_idle && (cnt_q == IW'(LIMIT - 1));

  always_comb begin
    if (!in_idle || expire) cnt_nxt = '0;
    else                    cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R9: the idle count never reaches the limit without triggering a wake-up
  assert_idle_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < IW'(LIMIT));

  // R9: count restarts whenever the sequencer leaves idle
  assert_idle_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> cnt_q == '0);

endmodule

// File: rtl/dramc_datapath.sv
module dramc_datapath
  import dramc_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  amux_t               amux_nxt,
  input  logic                rd_sample,
  input  logic                cas_n,
  input  logic [DATA_W-1:0]   dram_q,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic [DATA_W-1:0]   dram_d,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned PW = ADDR_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic [PW-1:0]     pin_q, pin_nxt;
  logic [ADDR_W-1:0] addr_src;

  assign addr_src = accept ? req_addr : addr_q;

  always_comb begin
    case (amux_nxt)
      AM_ROW:  pin_nxt = addr_src[ADDR_W-1 -: PW];
      AM_COL:  pin_nxt = addr_src[PW-1:0];
      default: pin_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (rd_sample) rd_q <= dram_q;
  end

  assign dram_addr = pin_q;
  assign dram_d    = wd_q;
  assign rdata     = rd_q;

  // R3: column address held while the column strobe is low
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

  // R7: write data held while the column strobe is low
  assert_wdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_d));

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned INIT_STROBES = 8,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_CAS        = 2,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned CNT_W        = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_write,
  input  logic  idle_expire,
  output logic  req_ready,
  output logic  accept,
  output logic  in_idle,
  output amux_t amux_nxt,
  output logic  rd_sample,
  output logic  done,
  output logic  ras_n,
  output logic  cas_n,
  output logic  we_n
);
  localparam int unsigned HOLD_CYC = (T_RAS > T_RCD + T_CAS) ? (T_RAS - T_RCD - T_CAS) : 0;
  localparam int unsigned STB_W    = $clog2(INIT_STROBES + 1);

  dram_st_t         st_q, st_nxt;
  logic [CNT_W-1:0] tmr_q, tmr_nxt;
  logic [STB_W-1:0] stb_q, stb_nxt;
  logic             wr_q, wr_nxt;
  logic             ras_q, cas_q, we_q, done_q;
  logic             tmr_end, cyc_end;
  logic             ras_lo_nxt, cas_lo_nxt, we_lo_nxt;

  assign tmr_end   = (tmr_q == '0);
  assign in_idle   = (st_q == ST_IDLE);
  assign req_ready = in_idle && !idle_expire;
  assign accept    = req_ready && req_valid;
  assign cyc_end   = (st_q == ST_COL) && tmr_end;
  assign rd_sample = cyc_end && !wr_q;

  always_comb begin
    st_nxt  = st_q;
    tmr_nxt = tmr_end ? tmr_q : tmr_q - 1'b1;
    stb_nxt = stb_q;
    wr_nxt  = wr_q;
    case (st_q)
      ST_PAUSE: if (tmr_end) begin
        st_nxt  = ST_WRAS;
        tmr_nxt = CNT_W'(T_RAS - 1);
        stb_nxt = '0;
      end
      ST_WRAS: if (tmr_end) begin
        st_nxt  = ST_WPRE;
        tmr_nxt = CNT_W'(T_RP - 1);
        stb_nxt = stb_q + 1'b1;
      end
      ST_WPRE: if (tmr_end) begin
        if (stb_q == STB_W'(INIT_STROBES)) begin
          st_nxt = ST_IDLE;
        end else begin
          st_nxt  = ST_WRAS;
          tmr_nxt = CNT_W'(T_RAS - 1);
        end
      end
      ST_IDLE: begin
        if (idle_expire) begin
          st_nxt  = ST_WRAS;
          tmr_nxt = CNT_W'(T_RAS - 1);
          stb_nxt = '0;
        end else if (req_valid) begin
          st_nxt  = ST_ROW;
          tmr_nxt = CNT_W'(T_RCD - 1);
          wr_nxt  = req_write;
        end
      end
      ST_ROW: if (tmr_end) begin
        st_nxt  = ST_COL;
        tmr_nxt = CNT_W'(T_CAS - 1);
      end
      ST_COL: if (tmr_end) begin
        if (HOLD_CYC > 0) begin
          st_nxt  = ST_HOLD;
          tmr_nxt = CNT_W'(HOLD_CYC - 1);
        end else begin
          st_nxt  = ST_PRE;
          tmr_nxt = CNT_W'(T_RP - 1);
        end
      end
      ST_HOLD: if (tmr_end) begin
        st_nxt  = ST_PRE;
        tmr_nxt = CNT_W'(T_RP - 1);
      end
      ST_PRE: if (tmr_end) st_nxt = ST_IDLE;
      default: st_nxt = ST_PAUSE;
    endcase
  end

  always_comb begin
    ras_lo_nxt = (st_nxt == ST_WRAS) || (st_nxt == ST_ROW) ||
                 (st_nxt == ST_COL)  || (st_nxt == ST_HOLD);
    cas_lo_nxt = (st_nxt == ST_COL);
    we_lo_nxt  = wr_nxt && ((st_nxt == ST_ROW) || (st_nxt == ST_COL));
    case (st_nxt)
      ST_ROW:  amux_nxt = AM_ROW;
      ST_COL:  amux_nxt = AM_COL;
      default: amux_nxt = AM_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      tmr_q  <= CNT_W'(PAUSE_CYC - 1);
      stb_q  <= '0;
      wr_q   <= 1'b0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      tmr_q  <= tmr_nxt;
      stb_q  <= stb_nxt;
      wr_q   <= wr_nxt;
      ras_q  <= !ras_lo_nxt;
      cas_q  <= !cas_lo_nxt;
      we_q   <= !we_lo_nxt;
      done_q <= cyc_end;
    end
  end

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign we_n  = we_q;
  assign done  = done_q;

  // R3: column strobe only inside a row-strobe window
  assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R8: ready only while the memory bus is quiet
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n));

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: write enable does not move while the column strobe is low
  assert_we_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(we_n));

  // R5: row strobe rises only with the column strobe already high
  assert_ras_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $past(cas_n) || cas_n);

endmodule

// File: rtl/dramc_top.sv
module dramc_top
  import dramc_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned PWRUP_US     = 200,
  parameter bit          LOW_POWER    = 1'b0,
  parameter int unsigned STD_IDLE_US  = 16000,
  parameter int unsigned LP_IDLE_US   = 128000,
  parameter int unsigned INIT_STROBES = 8,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_CAS        = 2,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned ADDR_W       = 22,
  parameter int unsigned DATA_W       = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                resp_done,
  output logic [DATA_W-1:0]   resp_rdata,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic [DATA_W-1:0]   dram_d,
  input  logic [DATA_W-1:0]   dram_q
);
  localparam int unsigned PAUSE_CYC  = CLK_MHZ * PWRUP_US;
  localparam int unsigned IDLE_LIMIT = CLK_MHZ * (LOW_POWER ? LP_IDLE_US : STD_IDLE_US);
  localparam int unsigned TMAX       = maxu(maxu(T_RAS, T_RP), maxu(T_RCD, T_CAS));
  localparam int unsigned CNT_W      = $clog2(maxu(PAUSE_CYC, TMAX) + 1);

  logic  idle_expire, accept, in_idle, rd_sample;
  amux_t amux_nxt;

  dramc_seq #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_STROBES(INIT_STROBES),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .idle_expire(idle_expire),
    .req_ready(req_ready), .accept(accept), .in_idle(in_idle),
    .amux_nxt(amux_nxt), .rd_sample(rd_sample), .done(resp_done),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n)
  );

  dramc_idle_mon #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n), .in_idle(in_idle), .expire(idle_expire)
  );

  dramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .amux_nxt(amux_nxt),
    .rd_sample(rd_sample), .cas_n(dram_cas_n), .dram_q(dram_q),
    .dram_addr(dram_addr), .dram_d(dram_d), .rdata(resp_rdata)
  );

endmodule

// File: tb/sim_dramc_top.sv
module sim_dramc_top;
  localparam int T_RCD = 3, T_CAS = 2, T_RAS = 8, T_RP = 3;
  localparam int PAUSE = 200, LIMIT = 300, NSTB = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, resp_done, ras_n, cas_n, we_n;
  logic [7:0] resp_rdata, dram_d, dram_q;
  logic [10:0] dram_addr;

  always #5 clk = ~clk;

  dramc_top #(.CLK_MHZ(1), .PWRUP_US(PAUSE), .STD_IDLE_US(LIMIT),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_rdata(resp_rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_addr(dram_addr), .dram_d(dram_d), .dram_q(dram_q));

  int total = 0, fails = 0;
  int e1 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0, e8 = 0;
  int cyc = 0, first_rf = -1, ras_lo = 0, ras_hi = 0, cas_lo = 0, since_rf = 0;
  int ras_only = 0, done_cnt = 0, acc_cnt = 0;
  bit saw_cas = 0, prev_ras = 1, prev_cas = 1, cas_we = 1;
  logic [10:0] row_at, m_row;
  logic [7:0] q_r = 0;
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic [21:0] p_addr; bit p_wr = 0, p_valid = 0; logic [7:0] p_wd;

  assign dram_q = cas_n ? 8'h00 : q_r;

  function automatic logic [7:0] dflt(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // memory model and protocol monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!ras_n && !prev_ras) begin ras_lo++; since_rf++; end
      if (ras_n && prev_ras) ras_hi++;
      if (!cas_n && !prev_cas) begin
        cas_lo++;
        if (we_n != cas_we) begin if (p_wr) e7++; else e6++; end
        if (p_valid && p_wr && dram_d != p_wd) e7++;
      end
      if (!ras_n && prev_ras) begin
        if (first_rf < 0) first_rf = cyc;
        else if (ras_hi < T_RP) e5++;
        ras_lo = 1; since_rf = 0; saw_cas = 0;
        row_at = dram_addr; m_row = dram_addr;
        if (p_valid && p_wr && we_n) e7++;
      end
      if (ras_n && !prev_ras) begin
        if (ras_lo < T_RAS) e5++;
        if (!saw_cas) ras_only++;
        ras_hi = 1;
      end
      if (!cas_n && prev_cas) begin
        saw_cas = 1; cas_lo = 1; cas_we = we_n;
        if (since_rf != T_RCD) e4++;
        if (!p_valid) e3++;
        else begin
          if (row_at != p_addr[21:11] || dram_addr != p_addr[10:0]) e3++;
          if (p_wr && we_n) e7++;
          if (!p_wr && !we_n) e6++;
          if (p_wr && dram_d != p_wd) e7++;
        end
        if (!we_n) mem[int'({m_row, dram_addr})] = dram_d;
        else q_r = mem.exists(int'({m_row, dram_addr})) ? mem[int'({m_row, dram_addr})]
                                                          : dflt({m_row, dram_addr});
      end
      if (cas_n && !prev_cas) begin
        if (cas_lo != T_CAS) e5++;
      end
      if (!cas_n && ras_n) e3++;
      if (req_ready && (!ras_n || !cas_n)) e8++;
      if (req_ready && first_rf < 0) e1++;
      if (resp_done) done_cnt++;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  task automatic do_req(input bit wr, input logic [21:0] a, input logic [7:0] wd);
    int lat; logic [7:0] ex;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    p_addr = a; p_wr = wr; p_wd = wd; p_valid = 1; acc_cnt++;
    ex = shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
    if (wr) shadow[int'(a)] = wd;
    @(negedge clk); req_valid = 0; lat = 1;
    while (!resp_done && lat < 100) begin @(negedge clk); lat++; end
    if (wr) check(lat == T_RCD + T_CAS + 1, "R7 write done latency", lat, T_RCD + T_CAS + 1);
    else begin
      check(lat == T_RCD + T_CAS + 1, "R6 read done latency", lat, T_RCD + T_CAS + 1);
      check(resp_rdata == ex, "R6 read data", resp_rdata, ex);
    end
    p_valid = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int snap, n, s;
    s = $urandom(32'h1234);
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n, "R8 reset strobes high", {ras_n, cas_n, we_n}, 7);
    check(!req_ready && !resp_done, "R8 reset ready/done low", {req_ready, resp_done}, 0);
    rst_n = 1;
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    check(first_rf > PAUSE, "R1 pause before first strobe", first_rf, PAUSE + 1);
    check(e1 == 0, "R1 ready low during pause", e1, 0);
    check(ras_only == NSTB, "R2 init strobes", ras_only, NSTB);

    // directed corners: extreme addresses, write then read back
    do_req(1, 22'h3FFFFF, 8'hA5);
    do_req(0, 22'h3FFFFF, 8'h00);
    do_req(1, 22'h000000, 8'h3C);
    do_req(0, 22'h000000, 8'h00);
    do_req(0, 22'h2AA555, 8'h00);

    snap = ras_only;
    for (int i = 0; i < 150; i++) begin
      logic [10:0] r, c; int g;
      case ($urandom % 4)
        0: r = 11'h000; 1: r = 11'h001; 2: r = 11'h7FF; default: r = 11'($urandom);
      endcase
      c = 11'($urandom % 16);
      g = $urandom % 20;
      repeat (g) @(negedge clk);
      do_req(1'($urandom % 2), {r, c}, 8'($urandom));
    end
    check(ras_only == snap, "R9 no wake on short idle", ras_only - snap, 0);

    // idle timer expiry exactly at the threshold
    do_req(1, 22'h155AAA, 8'h77);
    while (!req_ready) @(negedge clk);
    n = 0;
    snap = ras_only;
    while (req_ready && n < 1000) begin n++; @(negedge clk); end
    check(n == LIMIT - 1, "R9 ready drops at idle limit", n, LIMIT - 1);
    do_req(0, 22'h155AAA, 8'h00);
    check(ras_only - snap == NSTB, "R9 wake strobes before access", ras_only - snap, NSTB);
    do_req(0, 22'h3FFFFF, 8'h00);

    repeat (20) @(negedge clk);
    check(e3 == 0, "R3 address/strobe nesting errors", e3, 0);
    check(e4 == 0, "R4 row-to-column delay errors", e4, 0);
    check(e5 == 0, "R5 pulse width errors", e5, 0);
    check(e6 == 0, "R6 read write-enable errors", e6, 0);
    check(e7 == 0, "R7 early write errors", e7, 0);
    check(e8 == 0, "R8 ready during active cycle", e8, 0);
    check(done_cnt == acc_cnt, "R8 one done per accepted request", done_cnt, acc_cnt);
    report();
  end
endmodule